// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Recognition

This block is the receive half of an asynchronous serial port. It watches a serial input line at sixteen samples per bit. It finds the leading edge of a character and confirms it at mid-bit. It then gathers eight or nine data bits, least significant first, and checks the final high bit that closes the frame. Each finished character is placed in a holding register with a separate ninth-bit field. Four sticky flags report the state of that register: full, framing error, overrun and break.

A frame whose data bits are all zero and whose closing bit is also low counts as a line break. It is not stored as data. Instead it sets the break and framing flags and zeroes the holding register. Software clears the flags with a two-step sequence: a status read strobe, then a data read strobe. The serial input is assumed to be synchronous to the clock already. The oversampling tick is a one-cycle enable pulse from an outside baud divider.

Top module: `sci_rx_engine`

## Requirements
- R1: While reset is held, and right after it, the holding register, the ninth bit and all four flags read 0.
- R2: A character starts only on a tick where the line samples 0 after having sampled 1. The edge sample is phase 0. The start bit is accepted when at least two of the samples at phases 6, 7 and 8 are 0. Otherwise the engine drops the attempt with no effect on any output and waits for the next falling edge.
- R3: With the length select at 0, eight data bits follow the start bit, least significant first, 16 ticks per bit. When the closing bit is evaluated, the byte is loaded, the full flag sets and the ninth-bit output is 0. Outputs change on the clock edge of that evaluating tick.
- R4: With the length select at 1, nine data bits are received. The ninth received bit goes to the ninth-bit output, and the first eight go to the holding register.
- R5: Every bit value is the majority of its samples at phases 6, 7 and 8. A single disagreeing sample does not change the bit.
- R6: A frame whose closing bit votes 0, but whose data bits are not all zero, is stored normally and sets the framing flag. The break flag stays 0.
- R7: A frame with all data bits 0 (8 or 9, as selected) and a closing bit that votes 0 is a break. It sets the full, framing and break flags, and clears the holding register and the ninth bit to 0.
- R8: If a frame of any kind completes while the full flag is set, the overrun flag sets. The holding register, the ninth bit, the framing flag and the break flag keep their values.
- R9: A data read strobe clears all four flags, but only if a status read strobe came at some earlier cycle and no clear has happened since. A data read strobe on its own changes nothing. The holding register keeps its contents through a clear.
- R10: After any frame whose closing bit votes 0, including a break, no new character starts until the line has sampled 1 on at least one tick. A line held low is never taken as repeated start bits.
- R11: While the enable input is 0, the engine stays idle and receives nothing. The flags and the holding register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, one pulse per sample (16 per bit) |
| rxd | input | 1 | Serial input line, synchronous to clk |
| rx_en | input | 1 | Receiver enable |
| len9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| rx_data | output | 8 | Holding register, low eight data bits |
| rx_bit9 | output | 1 | Ninth data bit of the last loaded frame |
| rx_full | output | 1 | Receiver full flag |
| frame_err | output | 1 | Framing error flag |
| overrun | output | 1 | Overrun flag |
| brk_flag | output | 1 | Break flag |

## Verification
Some rules are checked by assertions on every cycle. These are that a break flag always comes with a set framing flag, a set full flag and a zero register. They also check that overrun never appears without full, that an overrun leaves the register untouched, that a qualified clear empties every flag, and that a frame only begins from a high-then-low line while the engine is enabled. Other behaviour shows only in the bench's scenarios, which a behavioural reference model follows on every clock. That covers majority voting across noisy samples, the rejection of short start pulses, the correct bit order in both lengths, and the refusal to restart on a line held low after a break.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;

  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RECV = 1'b1
  } fr_state_e;

  // two-of-three vote used for the start bit and every data bit
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // a break is an all-zero payload closed by a low stop vote
  function automatic logic break_kind(input logic all_zero, input logic stop_v);
    return all_zero & ~stop_v;
  endfunction

endpackage

// File: rtl/sci_rx_bittimer.sv
module sci_rx_bittimer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic start,
  input  logic run,
  output logic mid_tick,
  output logic bit_end,
  output logic vote
);
  import sci_rx_pkg::*;

  localparam int PW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [PW-1:0] P_A    = PW'(MID - 2);
  localparam logic [PW-1:0] P_B    = PW'(MID - 1);
  localparam logic [PW-1:0] P_C    = PW'(MID);
  localparam logic [PW-1:0] P_LAST = PW'(OSR - 1);

  logic [PW-1:0] ph;
  logic          samp_a, samp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      samp_a <= 1'b0;
      samp_b <= 1'b0;
    end else if (tick) begin
      if (start) begin
        ph <= PW'(1);
      end else if (run) begin
        ph <= ph + PW'(1);
        if (ph == P_A) samp_a <= rxd;
        if (ph == P_B) samp_b <= rxd;
      end
    end
  end

  assign mid_tick = tick && run && (ph == P_C);
  assign bit_end  = tick && run && (ph == P_LAST);
  assign vote     = maj3(samp_a, samp_b, rxd);

endmodule

// File: rtl/sci_rx_framer.sv
module sci_rx_framer #(
  parameter int OSR    = 16,
  parameter int DW_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              en,
  input  logic              len9,
  output logic              done,
  output logic [DW_MAX-1:0] word,
  output logic              stop_bit,
  output logic              brk_kind
);
  import sci_rx_pkg::*;

  localparam int IW = $clog2(DW_MAX + 2);

  fr_state_e         state;
  logic [IW-1:0]     bidx;
  logic              line_hi;
  logic [DW_MAX-1:0] word_q;
  logic [IW-1:0]     nbits;
  logic [IW-1:0]     stop_idx;
  logic              busy;
  logic              start_evt;
  logic              mid_tick, bit_end, vote;

  assign busy      = (state == FR_RECV);
  assign nbits     = len9 ? IW'(DW_MAX) : IW'(DW_MAX - 1);
  assign stop_idx  = nbits + IW'(1);
  assign start_evt = en && tick && !busy && line_hi && !rxd;

  sci_rx_bittimer #(.OSR(OSR)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rxd      (rxd),
    .start    (start_evt),
    .run      (busy),
    .mid_tick (mid_tick),
    .bit_end  (bit_end),
    .vote     (vote)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FR_IDLE;
      bidx    <= '0;
      line_hi <= 1'b0;
      word_q  <= '0;
    end else if (!en) begin
      state   <= FR_IDLE;
      bidx    <= '0;
      line_hi <= 1'b0;
    end else if (tick) begin
      if (!busy) begin
        line_hi <= rxd;
        if (start_evt) begin
          state  <= FR_RECV;
          bidx   <= '0;
          word_q <= '0;
        end
      end else begin
        if (mid_tick) begin
          if (bidx == '0) begin
            if (vote) begin
              state   <= FR_IDLE;
              line_hi <= 1'b1;
            end
          end else if (bidx == stop_idx) begin
            state   <= FR_IDLE;
            line_hi <= vote;
          end else begin
            for (int i = 0; i < DW_MAX; i++) begin
              if (bidx == IW'(i + 1)) word_q[i] <= vote;
            end
          end
        end
        if (bit_end) bidx <= bidx + IW'(1);
      end
    end
  end

  assign done     = en && mid_tick && (bidx == stop_idx);
  assign word     = word_q;
  assign stop_bit = vote;
  assign brk_kind = break_kind(word_q == '0, vote);

  // R2, R10: a frame begins only after a high sample followed by a low one
  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(line_hi) && !$past(rxd) && $past(en)));

  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  p_done_ends_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/sci_rx_regs.sv
module sci_rx_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW:0]   word,
  input  logic          stop_bit,
  input  logic          brk_kind,
  input  logic          len9,
  input  logic          stat_rd,
  input  logic          data_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          full,
  output logic          fe,
  output logic          ovr,
  output logic          brk
);

  logic armed;
  logic clr_evt, full_eff, load_evt, ovr_evt;

  assign clr_evt  = data_rd && armed;
  assign full_eff = full && !clr_evt;
  assign load_evt = done && !full_eff;
  assign ovr_evt  = done && full_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      full    <= 1'b0;
      fe      <= 1'b0;
      ovr     <= 1'b0;
      brk     <= 1'b0;
    end else begin
      if (stat_rd)      armed <= 1'b1;
      else if (clr_evt) armed <= 1'b0;
      if (clr_evt) begin
        full <= 1'b0;
        fe   <= 1'b0;
        ovr  <= 1'b0;
        brk  <= 1'b0;
      end
      if (ovr_evt) ovr <= 1'b1;
      if (load_evt) begin
        full <= 1'b1;
        if (brk_kind) begin
          rx_data <= '0;
          rx_bit9 <= 1'b0;
          fe      <= 1'b1;
          brk     <= 1'b1;
        end else begin
          rx_data <= word[DW-1:0];
          rx_bit9 <= len9 & word[DW];
          if (!stop_bit) fe <= 1'b1;
        end
      end
    end
  end

  p_brk_effects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> (fe && full && rx_data == '0 && !rx_bit9));

  p_ovr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> full);

  p_hold_on_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (ovr && $stable(rx_data) && $stable(rx_bit9) && $stable(brk)));

  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !done) |=> (!full && !fe && !ovr && !brk));

endmodule

// File: rtl/sci_rx_engine.sv
module sci_rx_engine #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 rx_en,
  input  logic                 len9,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_bit9,
  output logic                 rx_full,
  output logic                 frame_err,
  output logic                 overrun,
  output logic                 brk_flag
);

  localparam int DW_MAX = DATA_BITS + 1;

  logic              fr_done;
  logic [DW_MAX-1:0] fr_word;
  logic              fr_stop;
  logic              fr_brk;

  sci_rx_framer #(.OSR(OSR), .DW_MAX(DW_MAX)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rxd      (rxd),
    .en       (rx_en),
    .len9     (len9),
    .done     (fr_done),
    .word     (fr_word),
    .stop_bit (fr_stop),
    .brk_kind (fr_brk)
  );

  sci_rx_regs #(.DW(DATA_BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (fr_done),
    .word     (fr_word),
    .stop_bit (fr_stop),
    .brk_kind (fr_brk),
    .len9     (len9),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .rx_data  (rx_data),
    .rx_bit9  (rx_bit9),
    .full     (rx_full),
    .fe       (frame_err),
    .ovr      (overrun),
    .brk      (brk_flag)
  );

endmodule

// File: tb/sci_rx_engine_tb.sv
module sci_rx_engine_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, rxd = 1, rx_en = 1, len9 = 0, stat_rd = 0, data_rd = 0;
  logic [1:0] tdiv = 0;
  logic tick;
  logic [7:0] rx_data;
  logic rx_bit9, rx_full, frame_err, overrun, brk_flag;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  sci_rx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .rx_en(rx_en), .len9(len9),
    .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .rx_full(rx_full), .frame_err(frame_err), .overrun(overrun), .brk_flag(brk_flag)
  );

  // behavioural reference model, advanced on every clock
  int m_data, m_b9, m_full, m_fe, m_ovr, m_brk, m_arm;
  int m_act, m_hi, m_t, m_word, m_s6, m_s7;

  always @(posedge clk) begin
    int ph, bi, nb, v, clr;
    if (!rst_n) begin
      m_data = 0; m_b9 = 0; m_full = 0; m_fe = 0; m_ovr = 0; m_brk = 0; m_arm = 0;
      m_act = 0; m_hi = 0; m_t = 0; m_word = 0; m_s6 = 0; m_s7 = 0;
    end else begin
      clr = (data_rd && m_arm) ? 1 : 0;
      if (stat_rd) m_arm = 1; else if (clr != 0) m_arm = 0;
      if (clr != 0) begin m_full = 0; m_fe = 0; m_ovr = 0; m_brk = 0; end
      if (!rx_en) begin
        m_act = 0; m_hi = 0;
      end else if (tick) begin
        if (m_act == 0) begin
          if (m_hi != 0 && !rxd) begin m_act = 1; m_t = 0; m_word = 0; end
          m_hi = rxd ? 1 : 0;
        end else begin
          m_t = m_t + 1;
          ph = m_t % 16;
          bi = m_t / 16;
          nb = len9 ? 9 : 8;
          if (ph == 6) m_s6 = rxd ? 1 : 0;
          if (ph == 7) m_s7 = rxd ? 1 : 0;
          if (ph == 8) begin
            v = ((m_s6 + m_s7 + (rxd ? 1 : 0)) >= 2) ? 1 : 0;
            if (bi == 0) begin
              if (v != 0) begin m_act = 0; m_hi = 1; end
            end else if (bi <= nb) begin
              m_word = m_word | (v << (bi - 1));
            end else begin
              if (m_full != 0) m_ovr = 1;
              else begin
                m_full = 1;
                if (m_word == 0 && v == 0) begin
                  m_data = 0; m_b9 = 0; m_fe = 1; m_brk = 1;
                end else begin
                  m_data = m_word & 255;
                  m_b9 = (nb == 9) ? ((m_word >> 8) & 1) : 0;
                  if (v == 0) m_fe = 1;
                end
              end
              m_act = 0; m_hi = v;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3", "model rx_data", int'(rx_data), m_data);
      chk("R4", "model rx_bit9", int'(rx_bit9), m_b9);
      chk("R3", "model rx_full", int'(rx_full), m_full);
      chk("R6", "model frame_err", int'(frame_err), m_fe);
      chk("R8", "model overrun", int'(overrun), m_ovr);
      chk("R7", "model brk_flag", int'(brk_flag), m_brk);
    end
  end

  task automatic drive_tick(input logic v);
    rxd = v;
    @(posedge clk);
    while (!tick) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_tick(1'b1);
  endtask

  task automatic hold_low(input int n);
    for (int i = 0; i < n; i++) drive_tick(1'b0);
  endtask

  task automatic send_frame(input int w, input int nb, input logic stop, input int noise_bit);
    for (int b = 0; b <= nb + 1; b++) begin
      for (int p = 0; p < 16; p++) begin
        logic v;
        if (b == 0) v = 1'b0;
        else if (b <= nb) v = ((w >> (b - 1)) & 1) != 0;
        else v = stop;
        if (b == noise_bit && p == 7) v = ~v;
        drive_tick(v);
      end
    end
  endtask

  task automatic clear_flags();
    @(negedge clk) stat_rd = 1;
    @(negedge clk) begin stat_rd = 0; data_rd = 1; end
    @(negedge clk) data_rd = 0;
  endtask

  task automatic pulse_data_rd();
    @(negedge clk) data_rd = 1;
    @(negedge clk) data_rd = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "reset rx_full", int'(rx_full), 0);
    chk("R1", "reset rx_data", int'(rx_data), 0);
    chk("R1", "reset flags", int'({frame_err, overrun, brk_flag, rx_bit9}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "post-reset rx_full", int'(rx_full), 0);
    idle(20);

    // R3: plain byte, then R9 read sequences
    send_frame(8'hA5, 8, 1'b1, -1); idle(8);
    chk("R3", "byte A5", int'(rx_data), 8'hA5);
    chk("R3", "full set", int'(rx_full), 1);
    chk("R3", "ninth bit 0", int'(rx_bit9), 0);
    pulse_data_rd();
    chk("R9", "data_rd alone keeps full", int'(rx_full), 1);
    clear_flags();
    chk("R9", "full cleared", int'(rx_full), 0);
    chk("R9", "data kept through clear", int'(rx_data), 8'hA5);

    // R5: one noisy sample in data bit 2
    send_frame(8'h6B, 8, 1'b1, 3); idle(8);
    chk("R5", "vote beats noise", int'(rx_data), 8'h6B);
    clear_flags();

    // R2: short low pulse is rejected
    hold_low(7); idle(40);
    chk("R2", "false start no load", int'(rx_full), 0);
    chk("R2", "false start no fe", int'(frame_err), 0);
    send_frame(8'h81, 8, 1'b1, -1); idle(8);
    chk("R2", "receive after false start", int'(rx_data), 8'h81);
    clear_flags();

    // R4, R6, R7 in nine-bit mode
    len9 = 1; idle(4);
    send_frame(9'h1C3, 9, 1'b1, -1); idle(8);
    chk("R4", "nine-bit low byte", int'(rx_data), 8'hC3);
    chk("R4", "nine-bit bit9", int'(rx_bit9), 1);
    clear_flags();
    send_frame(9'h100, 9, 1'b0, -1); idle(8);
    chk("R6", "bit9-only frame fe", int'(frame_err), 1);
    chk("R6", "bit9-only not break", int'(brk_flag), 0);
    chk("R6", "bit9-only stored", int'(rx_bit9), 1);
    clear_flags();
    send_frame(0, 9, 1'b0, -1); idle(8);
    chk("R7", "nine-bit break flag", int'(brk_flag), 1);
    chk("R7", "nine-bit break bit9", int'(rx_bit9), 0);
    clear_flags();
    len9 = 0; idle(4);

    // R6: framing error on nonzero byte
    send_frame(8'h3C, 8, 1'b0, -1); idle(8);
    chk("R6", "fe set", int'(frame_err), 1);
    chk("R6", "no break", int'(brk_flag), 0);
    chk("R6", "data stored", int'(rx_data), 8'h3C);
    clear_flags();

    // R7 + R10: break, then line stays low
    send_frame(0, 8, 1'b0, -1);
    chk("R7", "break flag", int'(brk_flag), 1);
    chk("R7", "break fe", int'(frame_err), 1);
    chk("R7", "break full", int'(rx_full), 1);
    chk("R7", "break clears data", int'(rx_data), 0);
    hold_low(48);
    clear_flags();
    hold_low(48);
    chk("R10", "held low no restart", int'(rx_full), 0);
    idle(4);
    send_frame(8'h5A, 8, 1'b1, -1); idle(8);
    chk("R10", "restart after high", int'(rx_data), 8'h5A);
    chk("R10", "no break after restart", int'(brk_flag), 0);
    clear_flags();

    // R8: overrun by a byte and by a break
    send_frame(8'h11, 8, 1'b1, -1); idle(8);
    send_frame(8'h22, 8, 1'b1, -1); idle(8);
    chk("R8", "overrun set", int'(overrun), 1);
    chk("R8", "data held", int'(rx_data), 8'h11);
    send_frame(0, 8, 1'b0, -1); idle(8);
    chk("R8", "break while full keeps data", int'(rx_data), 8'h11);
    chk("R8", "break while full no brk flag", int'(brk_flag), 0);
    clear_flags();
    chk("R9", "overrun cleared", int'(overrun), 0);

    // R11: disabled receiver ignores traffic
    @(negedge clk) rx_en = 0;
    send_frame(8'h77, 8, 1'b1, -1); idle(8);
    chk("R11", "disabled no load", int'(rx_full), 0);
    chk("R11", "disabled data kept", int'(rx_data), 8'h11);
    @(negedge clk) rx_en = 1;
    idle(4);
    send_frame(8'h42, 8, 1'b1, -1); idle(8);
    chk("R11", "enabled again", int'(rx_data), 8'h42);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule